// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Arbitration

This block is a synchronous shared memory reachable from two independent ports, called left and right. Each port has the same controls: an enable, a write select, a read-output enable, an upper-half and a lower-half select, an address and write and read data. Either port can read or write any word in any cycle. Each half of the word can be written or returned on its own.

When both ports are enabled on the same word and at least one of them writes, the arbiter grants the word to one port. It raises a busy flag toward the other port and drops that port's write. In master mode the block makes this decision itself and drives the result on its busy outputs. In slave mode it makes no decision. It takes its busy flags from inputs instead, so that several instances placed side by side to widen the data path all honour one master's verdict.

A port that asserts its enable and its semaphore select together is making an illegal request. The block ignores that cycle and raises a one-cycle error flag for that port.

Top module: `twoport_arb_ram`

## Requirements
- R1: While reset is held and in the first cycle after it, `rdValidL`/`rdValidR` are 0, `rdDataL`/`rdDataR` are 0 and `modeErrL`/`modeErrR` are 0.
- R2: In master mode no busy flag is raised unless both ports are active on the same address and at least one of them writes. Two reads of one word in the same cycle raise no busy.
- R3: In master mode, if a collision starts while neither port kept its address from the previous cycle, the left port wins. `busyOutR` is 1 and `busyOutL` is 0.
- R4: A port that was active on the colliding address in the previous cycle, and is still on it, keeps the word. The newcomer gets busy until the holder drops its enable or moves. When both ports held the address, the previous winner keeps it.
- R5: A port whose busy flag is 1 has its write dropped, and memory keeps the old word.
- R6: In slave mode `busyOutL`/`busyOutR` equal `busyInL`/`busyInR` in the same cycle, and each port's write is blocked while its busy input is 1.
- R7: Byte lanes: the upper select covers bits [DATA_W-1:DATA_W/2] and the lower select covers bits [DATA_W/2-1:0], for both writes and reads. An unselected lane reads back as 0. With neither lane selected, no word changes and no read is reported.
- R8: A read is enable=1, write select=0, output enable=1 with a lane selected. Its data and a `rdValid` of 1 appear one cycle later. Any other cycle gives `rdValid` 0 and data 0.
- R9: If one port writes a word while the other reads it in the same cycle, the read returns the old contents. The new contents are returned from the next cycle.
- R10: A cycle with enable=1 and semaphore select=1 on a port causes no read, no write and no collision, and pulses that port's `modeErr` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | 1: take busy from inputs; 0: arbitrate locally |
| ceL | input | 1 | Left port enable |
| weL | input | 1 | Left write select (1 = write) |
| oeL | input | 1 | Left read-output enable |
| ubL | input | 1 | Left upper-lane select |
| lbL | input | 1 | Left lower-lane select |
| semL | input | 1 | Left semaphore select (illegal together with ceL) |
| addrL | input | ADDR_W | Left word address |
| wrDataL | input | DATA_W | Left write data |
| rdDataL | output | DATA_W | Left read data, one cycle after the request |
| rdValidL | output | 1 | Left read data is valid |
| busyInL | input | 1 | Left busy taken in slave mode |
| busyOutL | output | 1 | Effective busy toward the left port |
| modeErrL | output | 1 | Left illegal enable combination seen last cycle |
| ceR | input | 1 | Right port enable |
| weR | input | 1 | Right write select (1 = write) |
| oeR | input | 1 | Right read-output enable |
| ubR | input | 1 | Right upper-lane select |
| lbR | input | 1 | Right lower-lane select |
| semR | input | 1 | Right semaphore select (illegal together with ceR) |
| addrR | input | ADDR_W | Right word address |
| wrDataR | input | DATA_W | Right write data |
| rdDataR | output | DATA_W | Right read data, one cycle after the request |
| rdValidR | output | 1 | Right read data is valid |
| busyInR | input | 1 | Right busy taken in slave mode |
| busyOutR | output | 1 | Effective busy toward the right port |
| modeErrR | output | 1 | Right illegal enable combination seen last cycle |

## Verification
The bench drives both ports at a deliberately small set of addresses so that collisions are frequent. It targets four corner cases:
- Same-cycle starts: a design that let the right port win these would raise `busyOutL`.
- An address already held by one port: an arbiter with a fixed priority would take the word away from the holder.
- A write and a read to one word in the same cycle: a write-first memory would return the new data a cycle early.
- Slave mode: a slave that still arbitrated would show busy that differs from its inputs.

Contended writes, half-word writes and illegal-enable cycles are each followed by a readback. A loser write that leaked through, a lane mask that was swapped, or an illegal cycle that still wrote would each leave a wrong word behind.

// File: rtl/twoport_arb_pkg.sv
package twoport_arb_pkg;

  localparam int PORTS = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  // Per-port lane strobes from control to datapath
  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic rdHi;
    logic rdLo;
  } laneStb_t;

endpackage

// File: rtl/tparb_ctrl.sv
module tparb_ctrl
  import twoport_arb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          slaveMode,
  input  logic [PORTS-1:0]              ce,
  input  logic [PORTS-1:0]              we,
  input  logic [PORTS-1:0]              oe,
  input  logic [PORTS-1:0]              ub,
  input  logic [PORTS-1:0]              lb,
  input  logic [PORTS-1:0]              sem,
  input  logic [PORTS-1:0]              busyIn,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  output logic [PORTS-1:0]              busy,
  output logic [PORTS-1:0]              modeErr,
  output laneStb_t [PORTS-1:0]          stb
);

  logic [PORTS-1:0]             act;
  logic [PORTS-1:0]             held;
  logic [PORTS-1:0]             errNow;
  logic [PORTS-1:0]             rdReq;
  logic [PORTS-1:0]             wrOk;
  logic [PORTS-1:0]             locBusy;
  logic [PORTS-1:0]             prevAct;
  logic [PORTS-1:0][ADDR_W-1:0] prevAddr;
  logic                         match;
  logic                         leftWins;
  logic                         prevLeftWin;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign errNow[p] = ce[p] & sem[p];
    assign act[p]    = ce[p] & ~sem[p];
    assign held[p]   = prevAct[p] && (prevAddr[p] == addr[p]);
    assign rdReq[p]  = act[p] & ~we[p] & oe[p];
    assign wrOk[p]   = act[p] & we[p] & ~busy[p];
    assign stb[p]    = '{wrHi: wrOk[p] & ub[p],
                         wrLo: wrOk[p] & lb[p],
                         rdHi: rdReq[p] & ub[p],
                         rdLo: rdReq[p] & lb[p]};
  end

  // a collision needs a shared word and at least one writer
  assign match = act[LEFT] && act[RIGHT] && (addr[LEFT] == addr[RIGHT])
                 && (we[LEFT] || we[RIGHT]);

  always_comb begin
    if (held[LEFT] && held[RIGHT])       leftWins = prevLeftWin;
    else if (held[RIGHT] && !held[LEFT]) leftWins = 1'b0;
    else                                 leftWins = 1'b1;
  end

  assign locBusy[LEFT]  = match & ~leftWins;
  assign locBusy[RIGHT] = match & leftWins;
  assign busy           = slaveMode ? busyIn : locBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAct     <= '0;
      prevAddr    <= '0;
      modeErr     <= '0;
      prevLeftWin <= 1'b1;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        prevAct[p]  <= act[p];
        prevAddr[p] <= addr[p];
        modeErr[p]  <= errNow[p];
      end
      if (match) prevLeftWin <= leftWins;
    end
  end

endmodule

// File: rtl/tparb_datapath.sv
module tparb_datapath
  import twoport_arb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  laneStb_t [PORTS-1:0]          stb,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  input  logic [PORTS-1:0][DATA_W-1:0]  wrData,
  output logic [PORTS-1:0][DATA_W-1:0]  rdData,
  output logic [PORTS-1:0]              rdValid
);

  localparam int HALF_W = DATA_W / 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0]            bank [DEPTH];
    logic [PORTS-1:0]             laneWr;
    logic [PORTS-1:0]             laneRd;
    logic [PORTS-1:0][HALF_W-1:0] rdQ;

    for (genvar p = 0; p < PORTS; p++) begin : g_sel
      if (g == 1) begin : g_hi
        assign laneWr[p] = stb[p].wrHi;
        assign laneRd[p] = stb[p].rdHi;
      end else begin : g_lo
        assign laneWr[p] = stb[p].wrLo;
        assign laneRd[p] = stb[p].rdLo;
      end
      assign rdData[p][g*HALF_W +: HALF_W] = rdQ[p];
    end

    // right first so an unarbitrated double write leaves the left word
    always_ff @(posedge clk) begin
      if (laneWr[RIGHT]) bank[addr[RIGHT]] <= wrData[RIGHT][g*HALF_W +: HALF_W];
      if (laneWr[LEFT])  bank[addr[LEFT]]  <= wrData[LEFT][g*HALF_W +: HALF_W];
    end

    // reads sample the bank before this edge's writes land
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdQ <= '0;
      end else begin
        for (int p = 0; p < PORTS; p++)
          rdQ[p] <= laneRd[p] ? bank[addr[p]] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++)
        rdValid[p] <= stb[p].rdHi | stb[p].rdLo;
    end
  end

endmodule

// File: rtl/twoport_arb_ram.sv
module twoport_arb_ram
  import twoport_arb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              ceL,
  input  logic              weL,
  input  logic              oeL,
  input  logic              ubL,
  input  logic              lbL,
  input  logic              semL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wrDataL,
  output logic [DATA_W-1:0] rdDataL,
  output logic              rdValidL,
  input  logic              busyInL,
  output logic              busyOutL,
  output logic              modeErrL,
  input  logic              ceR,
  input  logic              weR,
  input  logic              oeR,
  input  logic              ubR,
  input  logic              lbR,
  input  logic              semR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wrDataR,
  output logic [DATA_W-1:0] rdDataR,
  output logic              rdValidR,
  input  logic              busyInR,
  output logic              busyOutR,
  output logic              modeErrR
);

  logic [PORTS-1:0]             busyV;
  logic [PORTS-1:0]             errV;
  logic [PORTS-1:0]             validV;
  logic [PORTS-1:0][ADDR_W-1:0] addrV;
  logic [PORTS-1:0][DATA_W-1:0] wrV;
  logic [PORTS-1:0][DATA_W-1:0] rdV;
  laneStb_t [PORTS-1:0]         stb;

  assign addrV = {addrR, addrL};
  assign wrV   = {wrDataR, wrDataL};

  tparb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slaveMode (slaveMode),
    .ce        ({ceR, ceL}),
    .we        ({weR, weL}),
    .oe        ({oeR, oeL}),
    .ub        ({ubR, ubL}),
    .lb        ({lbR, lbL}),
    .sem       ({semR, semL}),
    .busyIn    ({busyInR, busyInL}),
    .addr      (addrV),
    .busy      (busyV),
    .modeErr   (errV),
    .stb       (stb)
  );

  tparb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .addr    (addrV),
    .wrData  (wrV),
    .rdData  (rdV),
    .rdValid (validV)
  );

  assign busyOutL = busyV[LEFT];
  assign busyOutR = busyV[RIGHT];
  assign modeErrL = errV[LEFT];
  assign modeErrR = errV[RIGHT];
  assign rdDataL  = rdV[LEFT];
  assign rdDataR  = rdV[RIGHT];
  assign rdValidL = validV[LEFT];
  assign rdValidR = validV[RIGHT];

endmodule

// File: rtl/twoport_arb_ram_chk.sv
module twoport_arb_ram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              slaveMode,
  input logic              ceL,
  input logic              weL,
  input logic              oeL,
  input logic              semL,
  input logic [ADDR_W-1:0] addrL,
  input logic              rdValidL,
  input logic              busyInL,
  input logic              busyOutL,
  input logic              modeErrL,
  input logic              ceR,
  input logic              weR,
  input logic              semR,
  input logic [ADDR_W-1:0] addrR,
  input logic              busyInR,
  input logic              busyOutR,
  input logic              modeErrR
);

  // R3
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slaveMode |-> !(busyOutL && busyOutR));

  // R2
  busy_needs_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && (busyOutL || busyOutR)) |->
      (ceL && ceR && !semL && !semR && addrL == addrR && (weL || weR)));

  // R6
  slave_busy_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (busyOutL == busyInL && busyOutR == busyInR));

  // R8
  read_valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValidL |-> $past(ceL && oeL && !weL && !semL));

  // R10
  mode_err_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErrL |-> $past(ceL && semL));

  // R10
  mode_err_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErrR |-> $past(ceR && semR));

endmodule

bind twoport_arb_ram twoport_arb_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_twoport_arb_ram.sv
`timescale 1ns/1ps
module test_twoport_arb_ram;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, slaveMode;
  logic [1:0]  ce, we, oe, ub, lb, sem, busyIn;
  logic [5:0]  addr [2];
  logic [15:0] wd [2];
  logic [15:0] rdDataL, rdDataR;
  logic        rdValidL, rdValidR, busyOutL, busyOutR, modeErrL, modeErrR;

  twoport_arb_ram i_twoport_arb_ram (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .ceL(ce[0]), .weL(we[0]), .oeL(oe[0]), .ubL(ub[0]), .lbL(lb[0]), .semL(sem[0]),
    .addrL(addr[0]), .wrDataL(wd[0]), .rdDataL(rdDataL), .rdValidL(rdValidL),
    .busyInL(busyIn[0]), .busyOutL(busyOutL), .modeErrL(modeErrL),
    .ceR(ce[1]), .weR(we[1]), .oeR(oe[1]), .ubR(ub[1]), .lbR(lb[1]), .semR(sem[1]),
    .addrR(addr[1]), .wrDataR(wd[1]), .rdDataR(rdDataR), .rdValidR(rdValidR),
    .busyInR(busyIn[1]), .busyOutR(busyOutR), .modeErrR(modeErrR)
  );

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  logic [15:0] mm [64];
  bit          mPrevAct [2];
  logic [5:0]  mPrevAddr [2];
  bit          mPrevLeft = 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    ce = '0; we = '0; oe = '0; ub = '0; lb = '0; sem = '0; busyIn = '0;
    addr[0] = '0; addr[1] = '0; wd[0] = '0; wd[1] = '0;
  endtask

  task automatic setPort(int p, bit c, bit w, bit o, bit u, bit l, bit s,
                         logic [5:0] a, logic [15:0] d);
    ce[p] = c; we[p] = w; oe[p] = o; ub[p] = u; lb[p] = l; sem[p] = s;
    addr[p] = a; wd[p] = d;
  endtask

  // Inputs are set at a negedge; checks busy, clocks once, checks outputs.
  task automatic runCycle();
    bit act [2]; bit held [2]; bit eb [2]; bit eff [2];
    bit expV [2]; bit expErr [2]; bit rd;
    logic [15:0] expRd [2];
    bit match, lw;
    string tag;
    #1;
    for (int p = 0; p < 2; p++) begin
      act[p]  = ce[p] && !sem[p];
      held[p] = mPrevAct[p] && (mPrevAddr[p] == addr[p]);
    end
    match = act[0] && act[1] && (addr[0] == addr[1]) && (we[0] || we[1]);
    if (held[0] && held[1])      lw = mPrevLeft;
    else if (held[1] && !held[0]) lw = 0;
    else                          lw = 1;
    eb[0] = match && !lw;
    eb[1] = match && lw;
    if (slaveMode) begin
      chk("R6 busyOutL", busyOutL, busyIn[0]);
      chk("R6 busyOutR", busyOutR, busyIn[1]);
      eff[0] = busyIn[0]; eff[1] = busyIn[1];
    end else begin
      tag = !match ? "R2" : ((held[0] || held[1]) ? "R4" : "R3");
      chk({tag, " busyOutL"}, busyOutL, eb[0]);
      chk({tag, " busyOutR"}, busyOutR, eb[1]);
      eff[0] = eb[0]; eff[1] = eb[1];
    end
    for (int p = 0; p < 2; p++) begin
      rd = act[p] && !we[p] && oe[p];
      expRd[p] = '0;
      if (rd && ub[p]) expRd[p][15:8] = mm[addr[p]][15:8];
      if (rd && lb[p]) expRd[p][7:0]  = mm[addr[p]][7:0];
      expV[p]   = rd && (ub[p] || lb[p]);
      expErr[p] = ce[p] && sem[p];
    end
    for (int p = 1; p >= 0; p--) begin
      if (act[p] && we[p] && !eff[p]) begin
        if (ub[p]) mm[addr[p]][15:8] = wd[p][15:8];
        if (lb[p]) mm[addr[p]][7:0]  = wd[p][7:0];
      end
    end
    if (match) mPrevLeft = lw;
    for (int p = 0; p < 2; p++) begin
      mPrevAct[p]  = act[p];
      mPrevAddr[p] = addr[p];
    end
    @(posedge clk);
    @(negedge clk);
    chk("R8 rdValidL", rdValidL, expV[0]);
    chk("R8 rdValidR", rdValidR, expV[1]);
    chk("R7 R9 rdDataL", rdDataL, expRd[0]);
    chk("R7 R9 rdDataR", rdDataR, expRd[1]);
    chk("R10 modeErrL", modeErrL, expErr[0]);
    chk("R10 modeErrR", modeErrR, expErr[1]);
  endtask

  task automatic randPort(int p);
    setPort(p, ($urandom % 4) != 0, $urandom % 2, ($urandom % 4) != 0,
            ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 20) == 0,
            6'($urandom % 4), 16'($urandom));
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; slaveMode = 0;
    setIdle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rdValidL", rdValidL, 0);
    chk("R1 rdValidR", rdValidR, 0);
    chk("R1 rdDataL", rdDataL, 0);
    chk("R1 modeErrR", modeErrR, 0);
    rstN = 1;
    runCycle();
    chk("R1 rdDataR after release", rdDataR, 0);

    for (int a = 0; a < 8; a++) begin
      setIdle();
      setPort(0, 1, 1, 0, 1, 1, 0, 6'(a), 16'h1000 + 16'(a) * 16'h0111);
      runCycle();
    end

    // R2 both read one word
    setIdle();
    setPort(0, 1, 0, 1, 1, 1, 0, 6'd3, 16'h0);
    setPort(1, 1, 0, 1, 1, 1, 0, 6'd3, 16'h0);
    runCycle();

    // R3 and R5: simultaneous writes, left wins
    setIdle(); runCycle();
    setPort(0, 1, 1, 0, 1, 1, 0, 6'd1, 16'hAAAA);
    setPort(1, 1, 1, 0, 1, 1, 0, 6'd1, 16'hBBBB);
    runCycle();
    setIdle();
    setPort(0, 1, 0, 1, 1, 1, 0, 6'd1, 16'h0);
    runCycle();
    chk("R5 loser write dropped", rdDataL, 16'hAAAA);

    // R4: right holds addr 2, left arrives and loses
    setIdle();
    setPort(1, 1, 0, 1, 1, 1, 0, 6'd2, 16'h0);
    runCycle();
    setPort(0, 1, 1, 0, 1, 1, 0, 6'd2, 16'h5555);
    runCycle();
    chk("R4 holder keeps word", busyOutR, 0);
    setIdle();
    setPort(0, 1, 0, 1, 1, 1, 0, 6'd2, 16'h0);
    runCycle();
    chk("R5 held word unchanged", rdDataL, 16'h1222);

    // R7 upper-lane write, lower-lane read
    setIdle();
    setPort(0, 1, 1, 0, 1, 0, 0, 6'd4, 16'hABCD);
    runCycle();
    setPort(0, 1, 0, 1, 1, 1, 0, 6'd4, 16'h0);
    runCycle();
    chk("R7 upper lane only", rdDataL, 16'hAB44);
    setPort(0, 1, 0, 1, 0, 1, 0, 6'd4, 16'h0);
    runCycle();
    chk("R7 lower lane read", rdDataL, 16'h0044);

    // R9 write-read same cycle
    setIdle();
    setPort(0, 1, 1, 0, 1, 1, 0, 6'd5, 16'h7777);
    setPort(1, 1, 0, 1, 1, 1, 0, 6'd7, 16'h0);
    runCycle();
    setIdle();
    setPort(0, 1, 1, 0, 1, 1, 0, 6'd5, 16'h8888);
    setPort(1, 1, 0, 1, 1, 1, 0, 6'd5, 16'h0);
    runCycle();
    chk("R9 old data", rdDataR, 16'h7777);
    setIdle();
    setPort(1, 1, 0, 1, 1, 1, 0, 6'd5, 16'h0);
    runCycle();
    chk("R9 new data", rdDataR, 16'h8888);

    // R10 illegal enable combination
    setIdle();
    setPort(0, 1, 1, 0, 1, 1, 1, 6'd6, 16'hDEAD);
    runCycle();
    chk("R10 pulse ends", modeErrL, 1);
    setIdle();
    setPort(0, 1, 0, 1, 1, 1, 0, 6'd6, 16'h0);
    runCycle();
    chk("R10 no write", rdDataL, 16'h1666);
    chk("R10 pulse cleared", modeErrL, 0);

    // R8 read without output enable
    setIdle();
    setPort(1, 1, 0, 0, 1, 1, 0, 6'd6, 16'h0);
    runCycle();

    // random master
    for (int i = 0; i < 3000; i++) begin
      randPort(0); randPort(1); busyIn = 2'($urandom);
      runCycle();
    end

    // R6 directed slave gating
    slaveMode = 1;
    setIdle();
    busyIn = 2'b01;
    setPort(0, 1, 1, 0, 1, 1, 0, 6'd7, 16'h4242);
    runCycle();
    setIdle();
    setPort(0, 1, 0, 1, 1, 1, 0, 6'd7, 16'h0);
    runCycle();
    chk("R6 slave write blocked", rdDataL, 16'h1777);

    for (int i = 0; i < 1500; i++) begin
      randPort(0); randPort(1); busyIn = 2'($urandom);
      runCycle();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule